// File: doc/BRIEF.md
# Chained Bit-Slice Magnitude Comparator

This block compares two unsigned operands of a parameterised width and reports whether the first is greater than, less than or equal to the second. It is a purely combinational chain of identical one-bit comparison cells. Each cell receives one bit from each operand together with three relation flags from the cell below it, and passes three updated flags to the cell above.

The lowest cell is seeded with the constant "equal so far" state. The flags that leave the highest cell are the block's outputs. A cell whose two bits differ overrides whatever arrives from below. A cell whose bits match passes the incoming flags through unchanged. As a result, the most significant differing bit decides the answer, in the same way that a carry moves upward through a ripple adder.

Top module: `slice_mag_compare`

## Requirements
- R1: `a_gt` is 1 exactly when `op_a` is greater than `op_b`, with both read as unsigned numbers.
- R2: `a_lt` is 1 exactly when `op_a` is less than `op_b`, with both read as unsigned numbers.
- R3: `a_eq` is 1 exactly when `op_a` and `op_b` hold the same value.
- R4: For every operand pair, exactly one of `a_gt`, `a_lt` and `a_eq` is 1.
- R5: When the operands first differ at bit k, counting down from the top bit, the result follows bits k alone, whatever the lower bits hold. If `op_a[k]`=1 and `op_b[k]`=0 the result is greater; in the opposite case it is less.
- R6: The seed state at the lowest cell gives the equal result when no bit differs. This covers both all-zero operands and all-one operands.
- R7: The outputs follow the operands combinationally, with no clock and no register, so a new operand pair is reflected before the next sampling point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| a_gt | output | 1 | First operand is larger |
| a_lt | output | 1 | First operand is smaller |
| a_eq | output | 1 | Operands are identical |

## Verification
The hardest case to reach is a pair in which a high bit favours one operand while every lower bit favours the other. Only then does an override that leaks from a lower cell show up at the outputs. The stimulus reaches this case by sweeping every pair of 6-bit operands. This sweep includes all combinations of opposing lower bits under each differing top bit. It then adds directed pairs such as 100000 against 011111, and the reverse.

// File: rtl/slice_mag_compare.sv
module slice_mag_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             a_gt,
  output logic             a_lt,
  output logic             a_eq
);

  localparam int STAGES = WIDTH + 1;

  logic [STAGES-1:0] gt_link;
  logic [STAGES-1:0] lt_link;
  logic [STAGES-1:0] eq_link;

  assign eq_link[0] = 1'b1;
  assign gt_link[0] = 1'b0;
  assign lt_link[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic a_hi, b_hi, same;
    assign a_hi = op_a[i] & ~op_b[i];
    assign b_hi = ~op_a[i] & op_b[i];
    assign same = ~(op_a[i] ^ op_b[i]);

    assign gt_link[i+1] = a_hi | (same & gt_link[i]);
    assign lt_link[i+1] = b_hi | (same & lt_link[i]);
    assign eq_link[i+1] = same & eq_link[i];
  end

  assign a_gt = gt_link[WIDTH];
  assign a_lt = lt_link[WIDTH];
  assign a_eq = eq_link[WIDTH];

endmodule

module slice_mag_compare_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             a_gt,
  input logic             a_lt,
  input logic             a_eq
);
  always_comb begin
    a_r1_greater: assert (a_gt == (op_a > op_b));
    a_r2_less: assert (a_lt == (op_a < op_b));
    a_r3_equal: assert (a_eq == (op_a == op_b));
    a_r4_onehot: assert ($onehot({a_gt, a_lt, a_eq}));
  end
endmodule

bind slice_mag_compare slice_mag_compare_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .a_gt(a_gt), .a_lt(a_lt), .a_eq(a_eq)
);

// File: tb/slice_mag_compare_test.sv
module slice_mag_compare_test;
  localparam int W = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic a_gt, a_lt, a_eq;

  slice_mag_compare #(.WIDTH(W)) uut (
    .op_a(op_a), .op_b(op_b), .a_gt(a_gt), .a_lt(a_lt), .a_eq(a_eq)
  );

  typedef struct {
    logic [2:0] flags;
    string      tag;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit driving_done = 0;

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a;
    op_b = b;
    it.a = a;
    it.b = b;
    it.flags = {(a > b), (a < b), (a == b)};
    it.tag = tag;
    q.push_back(it);
  endtask

  function automatic string rel_tag(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a > b) return "R1";
    if (a < b) return "R2";
    return "R3";
  endfunction

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({a_gt, a_lt, a_eq} !== it.flags) begin
          failures++;
          $display("FAIL %s a=%0d b=%0d actual gt/lt/eq=%b expected=%b",
                   it.tag, it.a, it.b, {a_gt, a_lt, a_eq}, it.flags);
        end
        checks++;
        if ($countones({a_gt, a_lt, a_eq}) != 1) begin
          failures++;
          $display("FAIL R4 a=%0d b=%0d actual ones=%0d expected=1",
                   it.a, it.b, $countones({a_gt, a_lt, a_eq}));
        end
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    while (!driving_done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual cycles=%0d expected<=20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : driver
    drive('0, '0, "R6 zero");
    drive('1, '1, "R6 ones");
    drive(6'b100000, 6'b011111, "R5 top bit a");
    drive(6'b011111, 6'b100000, "R5 top bit b");
    drive(6'b010000, 6'b001111, "R5 bit4 a");
    drive(6'b101110, 6'b101101, "R5 bit1 a");
    drive(6'b000001, 6'b000000, "R1 lsb");
    drive(6'b000000, 6'b000001, "R2 lsb");
    drive(6'b101010, 6'b101010, "R3 pattern");
    drive(6'b111111, 6'b000000, "R7 flip max");
    drive(6'b000000, 6'b111111, "R7 flip min");
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        drive(a[W-1:0], b[W-1:0], rel_tag(a[W-1:0], b[W-1:0]));
      end
    end
    @(negedge clk);
    @(negedge clk);
    driving_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule